// File: doc/BRIEF.md
# Five-State Multicycle Processor Core

This is a 16-bit processor core in which every instruction follows the same five-phase route: instruction fetch, decode with register read, ALU, memory access and register write-back. Phases that have no work for a given instruction are still visited. The core has four general registers, a program counter and a memory address register. It supports three operations: a register-to-register add, a load of an immediate word, and a load from a direct memory address.

Instructions and data share one synchronous read port, and read data returns one cycle after the strobe. For this reason the fetch phase and the memory phase each take two clock cycles. Every instruction therefore takes exactly seven cycles. A one-cycle completion pulse marks the write-back cycle. A debug port shows the phase, the program counter and all registers.

Top module: `mc5_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the phase is 0 (fetch), the program counter is 0 and all four registers are 0.
- R2: Phases are encoded 0 fetch, 1 fetch-wait, 2 decode, 3 ALU, 4 memory, 5 memory-wait, 6 write-back. They advance by one every cycle, and phase 6 returns to 0, so every instruction takes 7 cycles.
- R3: Instruction word layout: bits [15:12] hold the opcode, [11:10] the destination, [9:8] the source, [7:6] the size, and [5:0] are ignored. Register indices are 0=AX, 1=BX, 2=CX, 3=DX. Size codes are 00 word, 01 low byte, 10 high byte, 11 word. Opcodes are 1 add, 2 load-immediate, 3 load-direct.
- R4: A word add writes (dst + src) mod 2^16 into dst.
- R5: Load-immediate writes the word that follows the instruction into dst.
- R6: Load-direct reads memory at the address held in the word that follows the instruction, and writes that data into dst. The read is issued in phase 4.
- R7: With a byte size, the operation uses only the selected byte of each operand. A byte add wraps mod 256, a byte load takes bits [7:0] of the data word, and the other byte of dst is left unchanged.
- R8: Opcodes other than 1, 2 and 3 change no register, advance the program counter by one, and still take 7 cycles.
- R9: `done` is high only in the write-back cycle: for one cycle per instruction.
- R10: `mem_rd` is high with `mem_addr` = PC in phase 0. It is high in phase 2 only for opcodes 2 and 3. It is high in phase 4 only for opcode 3. It is low in every other phase.
- R11: The PC rises by one at the end of fetch-wait, rises by one more at the end of decode for opcodes 2 and 3, and does not change in any other phase.
- R12: Registers change only at the end of the write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory word address |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| done | output | 1 | High in the write-back cycle |
| dbg_state | output | 3 | Current phase code |
| dbg_pc | output | 16 | Program counter |
| dbg_regs | output | 64 | Registers {DX, CX, BX, AX} |

## Verification
The checks assume that memory returns the addressed word exactly one cycle after each strobe. They also assume that `rst_n` is released away from the clock edge and that every fetched word is a defined value. The bench memory model registers read data on the edge that samples `mem_rd`, holds a fully initialised program and data area, and changes reset only at falling clock edges. Because the program ends with plain words and the run stops before the PC goes past the loaded area, no undefined word is ever decoded.

// File: rtl/mc5_pkg.sv
package mc5_pkg;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_FETCH_W = 3'd1,
    ST_DECODE  = 3'd2,
    ST_ALU     = 3'd3,
    ST_MEM     = 3'd4,
    ST_MEM_W   = 3'd5,
    ST_WB      = 3'd6
  } mc5_state_e;

  typedef enum logic [1:0] {
    SZ_WORD  = 2'd0,
    SZ_LO    = 2'd1,
    SZ_HI    = 2'd2,
    SZ_WORD2 = 2'd3
  } mc5_size_e;

  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_MOVI = 4'd2;
  localparam logic [3:0] OP_MOVM = 4'd3;

  localparam int NREG = 4;
  localparam int RW   = $clog2(NREG);

  // upper ten bits of an instruction word; the low six are dropped at fetch
  typedef struct packed {
    logic [3:0]      op;
    logic [RW-1:0]   dst;
    logic [RW-1:0]   src;
    mc5_size_e       size;
  } mc5_insn_t;

  function automatic logic has_opnd(input logic [3:0] op);
    return (op == OP_MOVI) || (op == OP_MOVM);
  endfunction

  function automatic logic [1:0] lane_mask(input mc5_size_e sz);
    case (sz)
      SZ_LO:   return 2'b01;
      SZ_HI:   return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/mc5_seq.sv
module mc5_seq
  import mc5_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output mc5_state_e state,
  output logic       done
);

  mc5_state_e state_q, state_d;

  always_comb begin
    case (state_q)
      ST_FETCH:   state_d = ST_FETCH_W;
      ST_FETCH_W: state_d = ST_DECODE;
      ST_DECODE:  state_d = ST_ALU;
      ST_ALU:     state_d = ST_MEM;
      ST_MEM:     state_d = ST_MEM_W;
      ST_MEM_W:   state_d = ST_WB;
      default:    state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign state = state_q;
  assign done  = (state_q == ST_WB);

endmodule

// File: rtl/mc5_regfile.sv
module mc5_regfile
  import mc5_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RW-1:0]    wr_idx,
  input  logic [1:0]       wr_lanes,
  input  logic [DW-1:0]    wr_data,
  input  logic [RW-1:0]    rd_a_idx,
  input  logic [RW-1:0]    rd_b_idx,
  output logic [DW-1:0]    rd_a,
  output logic [DW-1:0]    rd_b,
  output logic [NREG*DW-1:0] all_q
);

  localparam int BW = DW / 2;

  logic [BW-1:0] lane_q [NREG][2];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    for (genvar l = 0; l < 2; l++) begin : g_lane
      logic lane_en;
      assign lane_en = we && (wr_idx == RW'(r)) && wr_lanes[l];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lane_q[r][l] <= '0;
        else if (lane_en) lane_q[r][l] <= wr_data[l*BW +: BW];
      end
    end
    assign all_q[r*DW +: DW] = {lane_q[r][1], lane_q[r][0]};
  end

  assign rd_a = {lane_q[rd_a_idx][1], lane_q[rd_a_idx][0]};
  assign rd_b = {lane_q[rd_b_idx][1], lane_q[rd_b_idx][0]};

endmodule

// File: rtl/mc5_alu.sv
module mc5_alu
  import mc5_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  mc5_size_e     size,
  output logic [DW-1:0] y
);

  localparam int BW = DW / 2;

  logic [BW-1:0] a_byte, b_byte, s_byte;

  always_comb begin
    if (size == SZ_HI) begin
      a_byte = a[DW-1:BW];
      b_byte = b[DW-1:BW];
    end else begin
      a_byte = a[BW-1:0];
      b_byte = b[BW-1:0];
    end
    s_byte = a_byte + b_byte;
    if (size == SZ_LO || size == SZ_HI) y = {s_byte, s_byte};
    else                                y = a + b;
  end

endmodule

// File: rtl/mc5_core.sv
module mc5_core
  import mc5_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               mem_rd,
  output logic [DW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic               done,
  output logic [2:0]         dbg_state,
  output logic [DW-1:0]      dbg_pc,
  output logic [NREG*DW-1:0] dbg_regs
);

  localparam int BW = DW / 2;
  localparam int IW = $bits(mc5_insn_t);

  mc5_state_e    state;
  mc5_insn_t     ir_q;
  logic [DW-1:0] pc_q, mar_q, opa_q, opb_q, res_q;
  logic [DW-1:0] rd_a, rd_b, alu_y, load_val;
  logic          is_byte, opnd, is_movm, writes;
  logic          ir_en, pc_en, opr_en, mar_en, res_en;
  logic [DW-1:0] pc_d, res_d;

  mc5_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .done  (done)
  );

  assign is_byte = (ir_q.size == SZ_LO) || (ir_q.size == SZ_HI);
  assign opnd    = has_opnd(ir_q.op);
  assign is_movm = (ir_q.op == OP_MOVM);
  assign writes  = (ir_q.op == OP_ADD) || opnd;

  // load data: low byte copied into both lanes for byte sizes
  assign load_val = is_byte ? {mem_rdata[BW-1:0], mem_rdata[BW-1:0]} : mem_rdata;

  // memory port
  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = pc_q;
    case (state)
      ST_FETCH:  mem_rd = 1'b1;
      ST_DECODE: mem_rd = opnd;
      ST_MEM: begin
        mem_rd   = is_movm;
        mem_addr = mar_q;
      end
      default: ;
    endcase
  end

  // clock enables and next values
  assign ir_en  = (state == ST_FETCH_W);
  assign opr_en = (state == ST_DECODE);
  assign mar_en = (state == ST_ALU) && is_movm;
  assign pc_en  = (state == ST_FETCH_W) || ((state == ST_DECODE) && opnd);
  assign pc_d   = pc_q + DW'(1);

  always_comb begin
    res_en = 1'b0;
    res_d  = alu_y;
    if (state == ST_ALU && ir_q.op == OP_ADD) begin
      res_en = 1'b1;
    end else if (state == ST_ALU && ir_q.op == OP_MOVI) begin
      res_en = 1'b1;
      res_d  = load_val;
    end else if (state == ST_MEM_W && is_movm) begin
      res_en = 1'b1;
      res_d  = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= mc5_insn_t'(mem_rdata[DW-1 -: IW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (opr_en) begin
      opa_q <= rd_a;
      opb_q <= rd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mar_q <= '0;
    else if (mar_en) mar_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  mc5_alu #(.DW(DW)) u_alu (
    .a    (opa_q),
    .b    (opb_q),
    .size (ir_q.size),
    .y    (alu_y)
  );

  mc5_regfile #(.DW(DW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       ((state == ST_WB) && writes),
    .wr_idx   (ir_q.dst),
    .wr_lanes (lane_mask(ir_q.size)),
    .wr_data  (res_q),
    .rd_a_idx (ir_q.dst),
    .rd_b_idx (ir_q.src),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .all_q    (dbg_regs)
  );

  assign dbg_state = state;
  assign dbg_pc    = pc_q;

endmodule

// File: rtl/mc5_chk.sv
module mc5_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_rd,
  input logic [DW-1:0]   mem_addr,
  input logic            done,
  input logic [2:0]      dbg_state,
  input logic [DW-1:0]   dbg_pc,
  input logic [4*DW-1:0] dbg_regs
);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state != 3'd6) |=> (dbg_state == $past(dbg_state) + 3'd1));

  // R2
  seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd6) |=> (dbg_state == 3'd0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (dbg_state == 3'd0));

  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd1 || dbg_state == 3'd3 || dbg_state == 3'd5 || dbg_state == 3'd6)
      |-> !mem_rd);

  // R10
  rd_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd0) |-> (mem_rd && mem_addr == dbg_pc));

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd1) |=> (dbg_pc == $past(dbg_pc) + DW'(1)));

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 3'd0 || dbg_state >= 3'd3) |=> $stable(dbg_pc));

  // R12
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state != 3'd6) |=> $stable(dbg_regs));

endmodule

bind mc5_core mc5_chk #(.DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .done      (done),
  .dbg_state (dbg_state),
  .dbg_pc    (dbg_pc),
  .dbg_regs  (dbg_regs)
);

// File: tb/test_mc5_core.sv
`timescale 1ns/1ps
module test_mc5_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        done;
  logic [2:0]  dbg_state;
  logic [15:0] dbg_pc;
  logic [63:0] dbg_regs;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  mc5_core i_mc5_core (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .dbg_state(dbg_state),
    .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  logic [15:0] mem [256];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  typedef struct packed {
    logic [15:0] ins;
    logic [15:0] opd;
    logic        has;
    logic [1:0]  rix;
    logic [15:0] val;
    logic [15:0] pc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{16'h2000, 16'h0003, 1'b1, 2'd0, 16'h0003, 16'd2},  // R5 AX=3
    '{16'h2400, 16'h0001, 1'b1, 2'd1, 16'h0001, 16'd4},  // R5 BX=1
    '{16'h1100, 16'h0000, 1'b0, 2'd0, 16'h0004, 16'd5},  // R4 AX+=BX
    '{16'h3800, 16'h0080, 1'b1, 2'd2, 16'hBEEF, 16'd7},  // R6 CX=[80]
    '{16'h2C00, 16'hFFFF, 1'b1, 2'd3, 16'hFFFF, 16'd9},  // R5 DX=FFFF
    '{16'h1C00, 16'h0000, 1'b0, 2'd3, 16'h0003, 16'd10}, // R4 wrap
    '{16'h2840, 16'h1177, 1'b1, 2'd2, 16'hBE77, 16'd12}, // R7 CL
    '{16'h2880, 16'hAB12, 1'b1, 2'd2, 16'h1277, 16'd14}, // R7 CH
    '{16'h1240, 16'h0000, 1'b0, 2'd0, 16'h007B, 16'd15}, // R7 AL+=CL
    '{16'h1680, 16'h0000, 1'b0, 2'd1, 16'h1201, 16'd16}, // R7 BH+=CH
    '{16'h3080, 16'h0081, 1'b1, 2'd0, 16'h347B, 16'd18}, // R7 AH=[81]
    '{16'hF03F, 16'h0000, 1'b0, 2'd0, 16'h347B, 16'd19}, // R8 undefined
    '{16'h3C40, 16'h00FF, 1'b1, 2'd3, 16'h00A5, 16'd21}, // R7 DL=[FF]
    '{16'h1F40, 16'h0000, 1'b0, 2'd3, 16'h004A, 16'd22}, // R7 DL wrap
    '{16'h24C0, 16'h5555, 1'b1, 2'd1, 16'h5555, 16'd24}, // R3 size 11
    '{16'h1600, 16'h0000, 1'b0, 2'd1, 16'h67CC, 16'd25}  // R4 BX+=CX
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // counts cycles after the current one until done is seen
  task automatic wait_done(output int cyc, inout int rds, input logic [15:0] opd,
                           input logic movm);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (mem_rd) rds++;
      if (dbg_state == 3'd4 && movm)
        check("R6 address", {48'd0, mem_addr}, {48'd0, opd});
    end while (!done && cyc < 40);
  endtask

  initial begin
    int cyc, rds, exp_rds;
    logic [63:0] exp_regs;
    logic [15:0] waddr;

    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[8'h80] = 16'hBEEF;
    mem[8'h81] = 16'h1234;
    mem[8'hFF] = 16'h00A5;
    waddr = 0;
    for (int i = 0; i < NV; i++) begin
      mem[waddr[7:0]] = VEC[i].ins;
      waddr++;
      if (VEC[i].has) begin
        mem[waddr[7:0]] = VEC[i].opd;
        waddr++;
      end
    end

    repeat (3) @(negedge clk);
    // R1 values while reset is held
    check("R1 state", {61'd0, dbg_state}, 64'd0);
    check("R1 pc", {48'd0, dbg_pc}, 64'd0);
    check("R1 regs", dbg_regs, 64'd0);
    rst_n = 1'b1;
    rds = mem_rd ? 1 : 0;
    exp_regs = '0;

    for (int i = 0; i < NV; i++) begin
      exp_rds = 1 + (VEC[i].has ? 1 : 0) + (VEC[i].ins[15:12] == 4'd3 ? 1 : 0);
      wait_done(cyc, rds, VEC[i].opd, VEC[i].ins[15:12] == 4'd3);
      // R2: six more cycles after the fetch cycle, then write-back
      check($sformatf("R2 cycles v%0d", i), 64'(cyc), 64'd6);
      check($sformatf("R2 wb state v%0d", i), {61'd0, dbg_state}, 64'd6);
      check($sformatf("R10 reads v%0d", i), 64'(rds), 64'(exp_rds));
      exp_regs[VEC[i].rix*16 +: 16] = VEC[i].val;
      @(negedge clk);
      rds = mem_rd ? 1 : 0;
      check($sformatf("R9 done low v%0d", i), {63'd0, done}, 64'd0);
      check($sformatf("R4 R5 R6 R7 R8 regs v%0d", i), dbg_regs, exp_regs);
      check($sformatf("R11 pc v%0d", i), {48'd0, dbg_pc}, {48'd0, VEC[i].pc});
    end

    // R1: reset in the middle of an instruction
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid state", {61'd0, dbg_state}, 64'd0);
    check("R1 mid pc", {48'd0, dbg_pc}, 64'd0);
    check("R1 mid regs", dbg_regs, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 after release", {61'd0, dbg_state}, 64'd0);
    rds = mem_rd ? 1 : 0;
    wait_done(cyc, rds, 16'h0000, 1'b0);
    check("R2 cycles after reset", 64'(cyc), 64'd6);
    @(negedge clk);
    check("R5 rerun AX", dbg_regs, 64'h0000_0000_0000_0003);
    check("R11 rerun pc", {48'd0, dbg_pc}, 64'd2);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #20000;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule